// File: doc/BRIEF.md
# Token-Enabled Register FIFO

This block is a synchronous first-in first-out buffer built from register rows that never move their contents. A one-hot write token circulates around the rows. On each accepted push, only the row that holds the token is enabled, so only that row loads the write word. The write word is wired to every row in parallel, and all other rows keep their value. A second one-hot token marks the oldest entry. An AND-OR selector uses it to drive the read port. Because no data ripples through a chain, the storage flops stay idle except for the one row taking a new word. The per-row enables are the points where a clock-gating cell would sit in silicon.

An occupancy counter produces the full and empty flags. A wrapping counter of row writes lets a bench or monitor measure storage activity. Depth, word width and the activity counter width are parameters.

Top module: `lp_token_fifo`

## Requirements
- R1: While reset is asserted (rstN low) and right after it is released, empty is 1, full is 0 and rowWriteCount is 0. Both tokens start at row 0.
- R2: Words leave in the order they were accepted. Whenever empty is 0, dataOut shows the oldest stored word, with no extra cycle after the push that stored it.
- R3: full is 1 exactly when DEPTH words are held, and empty is 1 exactly when none are held. The two flags are never both 1.
- R4: A push while full is 1 is ignored. Stored words, their order and rowWriteCount are unchanged. A pop in the same cycle is still accepted.
- R5: A pop while empty is 1 is ignored. The flags and later ordering are unaffected. A push in the same cycle is still accepted.
- R6: When a push and a pop are both accepted in one cycle, the occupancy and both flags are unchanged.
- R7: Each accepted push writes exactly one row, and every other row holds its value. This shows up as intact data after the tokens have wrapped around the rows many times.
- R8: rowWriteCount increases by exactly 1 on each accepted push and holds otherwise. It wraps modulo 2^CNT_W.
- R9: The write token moves to the next row only on an accepted push. The read token moves only on an accepted pop. Both wrap from row DEPTH-1 to row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| push | input | 1 | Write request |
| pop | input | 1 | Read request |
| dataIn | input | WIDTH | Word to store, broadcast to all rows |
| dataOut | output | WIDTH | Oldest stored word |
| full | output | 1 | DEPTH words held |
| empty | output | 1 | No words held |
| rowWriteCount | output | CNT_W | Wrapping count of row writes |

## Verification
The flags, rowWriteCount and the data word from an accepted push all become visible one clock edge after the request. A push into an empty buffer therefore appears on dataOut right after that edge. After a pop, the next word appears combinationally once the read token has moved on the same edge. The bench drives requests on the falling edge and updates its reference queue once the rising edge has passed. It compares every output 1 ns after that edge, before the next drive, so each check sees exactly one edge of change. Directed phases cover filling to full, rejected pushes, rejected pops and simultaneous traffic. A long random run then wraps the tokens many times.

// File: rtl/lp_fifo_pkg.sv
`timescale 1ns/1ps
package lp_fifo_pkg;
  // Strobes from control to storage
  typedef struct packed {
    logic write;   // accepted push this cycle
    logic read;    // accepted pop this cycle
  } fifoStrobeT;
endpackage

// File: rtl/lp_fifo_ctrl.sv
`timescale 1ns/1ps
module lp_fifo_ctrl
  import lp_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  output fifoStrobeT        strobe,
  output logic [DEPTH-1:0]  wrTok,
  output logic [DEPTH-1:0]  rdTok,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  rowWriteCount
);
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(DEPTH);

  logic [OCC_W-1:0] occ;
  logic pushOk, popOk;

  assign full   = (occ == OCC_MAX);
  assign empty  = (occ == '0);
  assign pushOk = push && !full;
  assign popOk  = pop && !empty;

  always_comb begin
    strobe       = '0;
    strobe.write = pushOk;
    strobe.read  = popOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ <= '0;
    end else begin
      case ({pushOk, popOk})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  // Rotating one-hot tokens
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrTok <= DEPTH'(1);
      rdTok <= DEPTH'(1);
    end else begin
      if (pushOk) wrTok <= {wrTok[DEPTH-2:0], wrTok[DEPTH-1]};
      if (popOk)  rdTok <= {rdTok[DEPTH-2:0], rdTok[DEPTH-1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rowWriteCount <= '0;
    else if (pushOk) rowWriteCount <= rowWriteCount + 1'b1;
  end

  // R3
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

  // R4
  push_full_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (full && $stable(rowWriteCount)));

  // R5
  pop_empty_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push) |=> empty);

  // R6
  both_keep_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop && !full && !empty) |=> ($stable(full) && $stable(empty)));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.write |=> (rowWriteCount == CNT_W'($past(rowWriteCount) + 1'b1)));

  // R9
  tokens_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($onehot(wrTok) && $onehot(rdTok)));

  // R9
  wr_token_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.write |=> $stable(wrTok));
endmodule

// File: rtl/lp_fifo_store.sv
`timescale 1ns/1ps
module lp_fifo_store
  import lp_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobeT        strobe,
  input  logic [DEPTH-1:0]  wrTok,
  input  logic [DEPTH-1:0]  rdTok,
  input  logic [WIDTH-1:0]  dataIn,
  output logic [WIDTH-1:0]  dataOut
);
  logic [WIDTH-1:0] rows [DEPTH];
  logic [DEPTH-1:0] rowEn;

  // Per-row enables stand in for gated clocks
  assign rowEn = wrTok & {DEPTH{strobe.write}};

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (rowEn[i]) rows[i] <= dataIn;
    end
  end

  // One-hot AND-OR read selector
  always_comb begin
    dataOut = '0;
    for (int i = 0; i < DEPTH; i++) begin
      dataOut = dataOut | (rows[i] & {WIDTH{rdTok[i]}});
    end
  end

  // R7
  single_row_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowEn));
endmodule

// File: rtl/lp_token_fifo.sv
`timescale 1ns/1ps
module lp_token_fifo
  import lp_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [WIDTH-1:0]  dataIn,
  output logic [WIDTH-1:0]  dataOut,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  rowWriteCount
);
  fifoStrobeT       strobe;
  logic [DEPTH-1:0] wrTok;
  logic [DEPTH-1:0] rdTok;

  lp_fifo_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .push(push), .pop(pop),
    .strobe(strobe), .wrTok(wrTok), .rdTok(rdTok),
    .full(full), .empty(empty), .rowWriteCount(rowWriteCount)
  );

  lp_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrTok(wrTok), .rdTok(rdTok),
    .dataIn(dataIn), .dataOut(dataOut)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |-> (empty && !full && rowWriteCount == '0));
endmodule

// File: tb/test_lp_token_fifo.sv
`timescale 1ns/1ps
module test_lp_token_fifo;
  localparam int DEPTH = 8;
  localparam int WIDTH = 16;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic push = 1'b0, pop = 1'b0;
  logic [WIDTH-1:0] dataIn = '0;
  logic [WIDTH-1:0] dataOut;
  logic full, empty;
  logic [CNT_W-1:0] rowWriteCount;

  int vecCnt = 0;
  int errCnt = 0;
  logic [WIDTH-1:0] model[$];
  logic [CNT_W-1:0] expCount = '0;
  int seed = 32'h5eed_1234;

  always #2.5 clk = ~clk;

  lp_token_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W)) i_lp_token_fifo (
    .clk(clk), .rstN(rstN), .push(push), .pop(pop), .dataIn(dataIn),
    .dataOut(dataOut), .full(full), .empty(empty), .rowWriteCount(rowWriteCount)
  );

  function automatic logic expFull();
    return model.size() == DEPTH;
  endfunction

  function automatic logic expEmpty();
    return model.size() == 0;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk((tag == "") ? "R3" : tag, "full",  full,  expFull());
    chk((tag == "") ? "R3" : tag, "empty", empty, expEmpty());
    chk("R8", "rowWriteCount", rowWriteCount, expCount);
    if (!expEmpty()) chk("R2", "dataOut", dataOut, model[0]);
  endtask

  // One clock: drive at falling edge, update reference after rising edge
  task automatic step(input logic p, input logic q, input logic [WIDTH-1:0] d, input string tag);
    logic pushOk, popOk;
    @(negedge clk);
    push = p; pop = q; dataIn = d;
    pushOk = p && !expFull();
    popOk  = q && !expEmpty();
    @(posedge clk);
    #1;
    if (popOk) void'(model.pop_front());
    if (pushOk) begin
      model.push_back(d);
      expCount = expCount + 1'b1;
    end
    checkAll(tag);
  endtask

  initial begin
    #1000000;
    errCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    // R1: reset state
    #12;
    chk("R1", "empty in reset", empty, 1);
    chk("R1", "full in reset", full, 0);
    chk("R1", "count in reset", rowWriteCount, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1", "empty after reset", empty, 1);
    chk("R1", "count after reset", rowWriteCount, 0);

    // R5: pop on empty ignored
    step(1'b0, 1'b1, 16'h0, "R5");
    step(1'b0, 1'b1, 16'h0, "R5");
    // R5: push and pop on empty -> push only
    step(1'b1, 1'b1, 16'hA5A5, "R5");
    step(1'b0, 1'b1, 16'h0, "R5");

    // R3: fill to full, R9 write token reaches last row
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 16'h1000 + 16'(i), "R3");
    chk("R3", "full after DEPTH pushes", full, 1);

    // R4: pushes while full ignored
    step(1'b1, 1'b0, 16'hDEAD, "R4");
    step(1'b1, 1'b0, 16'hBEEF, "R4");
    chk("R4", "count after rejected pushes", rowWriteCount, CNT_W'(DEPTH + 1));
    // R4: push and pop when full -> pop only
    step(1'b1, 1'b1, 16'hCAFE, "R4");
    chk("R4", "one slot free", full, 0);

    // R6: simultaneous traffic at mid occupancy
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 16'h2000 + 16'(i), "R6");

    // R2 / R9: drain in order, wrapping read token
    while (model.size() > 0) step(1'b0, 1'b1, 16'h0, "R2");
    chk("R3", "empty after drain", empty, 1);

    // R7 / R9: long random run wraps tokens many times
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom(seed);
      seed = seed + 1;
      step(r[0] | r[1], r[2] & (r[3] | r[4]), r[31:16], "R7");
    end
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom(seed);
      seed = seed + 1;
      step(r[0] & r[1], r[2] | r[3], r[31:16], "R9");
    end
    while (model.size() > 0) step(1'b0, 1'b1, 16'h0, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule